// File: doc/BRIEF.md
# Repetition-Period Sequence Controller

This block times one acquisition or excitation module through each repetition period of a pulse sequence. A rising edge on the sync input starts a period. From then on the block counts sample-clock enables, which are single-cycle strobes in the system clock domain. It steps through a small table of sequence elements, where each element has a start count, a length in samples and a kind. While the count lies inside the current element's window, the block raises a transfer request to the waveform DMA engine on every sample tick. It also drives the gate line that belongs to the element's kind: transmit, receive or gradient.

The host tops up a credit counter with a one-cycle "period loaded" strobe. Each period that starts uses one credit. If a sync edge arrives while no credit is left, the block has run out of prepared periods. It then parks in a sticky stopped state instead of replaying stale data. A pause input freezes the period in place. A halt input stops the scan at once. A sync edge that arrives while a period is still running is dropped, and a sticky overrun flag records it.

Top module: `tr_sequencer`

## Requirements
- R1: After reset, busy, stopped, overrun, dma_req and all gate bits are low and elem_idx is 0.
- R2: A rising edge of sync_in in the idle state, with at least one credit held, starts a period on the next clock. The sample count is 0, elem_idx is 0 and busy is high.
- R3: The sample count advances only on cycles with smp_en high and pause low. dma_req is high on exactly those cycles on which the count c satisfies start <= c < start+length of the current element.
- R4: Elements run in table order from entry 0 to entry tbl_count-1, and elem_idx names the element in progress. An entry of length 0 produces no request and no gate, and takes one system clock to skip.
- R5: The kind field is 2 bits per entry. Code 0 drives gate[0] (transmit), code 1 drives gate[1] (receive), code 2 drives gate[2] (gradient) and code 3 drives no gate but still requests. A gate is high exactly while the count is inside that element's window, and at most one gate bit is high.
- R6: On the clock edge that ends the last sample of the final element, busy falls and the block returns to idle. A later sync edge can then start a new period.
- R7: A sync edge while busy does not restart or disturb the running period, and it sets overrun, which stays high until reset.
- R8: Each tr_loaded strobe adds a credit, up to CREDIT_MAX (default 2). Each period start uses one credit. A sync edge in idle with no credit moves the block to stopped instead of starting.
- R9: Stopped holds until reset. While stopped, no request is made, all gates are low, busy is low, and sync edges and loads have no effect.
- R10: While pause is high, the sample count and elem_idx hold, dma_req is low, and the gates keep their current values.
- R11: halt moves the block from any state to stopped on the next clock, which drops busy, dma_req and the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Period sync; its rising edge starts a period |
| smp_en | input | 1 | One-cycle sample-clock enable |
| tr_loaded | input | 1 | Host strobe: one more period prepared |
| pause | input | 1 | Freeze the running period |
| halt | input | 1 | Stop the scan immediately |
| tbl_start | input | NUM_ELEM*START_W | Start count of each entry, entry i at bits [i*START_W +: START_W] |
| tbl_len | input | NUM_ELEM*LEN_W | Length in samples of each entry |
| tbl_kind | input | NUM_ELEM*2 | Kind code of each entry |
| tbl_count | input | IDX_W | Number of valid entries |
| dma_req | output | 1 | Per-sample transfer request |
| elem_idx | output | IDX_W | Index of the element in progress |
| gate | output | 3 | Transmit, receive and gradient gates (bits 0, 1, 2) |
| busy | output | 1 | A period is running |
| stopped | output | 1 | Sticky stopped status |
| overrun | output | 1 | Sticky flag: sync edge arrived while busy |

## Verification
The properties assume that the table is held steady while a period runs. They also assume that entries are sorted by start count and do not overlap, and that the table has no more than NUM_ELEM valid entries. When a zero-length entry comes in, the entry after it must start at least one sample later. The bench loads each table only while the block is idle or in reset, and every table it builds is ordered with gaps after each zero-length entry. smp_en and pause are driven as whole-cycle levels away from the clock edge, so every request seen at a sample point belongs to exactly one tick.

// File: rtl/trseq_pkg.sv
package trseq_pkg;

    localparam int KIND_W = 2;
    localparam int GATE_W = 3;

    typedef enum logic [KIND_W-1:0] {
        EL_TX   = 2'd0,
        EL_RX   = 2'd1,
        EL_GRAD = 2'd2,
        EL_MARK = 2'd3
    } el_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } seq_state_t;

    // Result of comparing the sample count with the current entry
    typedef struct packed {
        logic     hit;   // count inside the window
        logic     last;  // count is the final sample of the window
        logic     zero;  // current entry has zero length
        el_kind_t kind;
    } win_t;

    function automatic logic [GATE_W-1:0] kind_gate(el_kind_t k);
        case (k)
            EL_TX:   return 3'b001;
            EL_RX:   return 3'b010;
            EL_GRAD: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/trseq_edge.sv
module trseq_edge (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

    assign rise = d & ~q;
endmodule

// File: rtl/trseq_credit.sv
module trseq_credit #(
    parameter  int MAX = 2,
    localparam int CW  = $clog2(MAX + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic give,
    input  logic take,
    output logic avail
);
    logic [CW-1:0] n;

    always_ff @(posedge clk) begin
        if (rst)
            n <= '0;
        else if (take && !give && n != '0)
            n <= n - 1'b1;
        else if (give && !take && n != CW'(MAX))
            n <= n + 1'b1;
    end

    assign avail = (n != '0);
endmodule

// File: rtl/trseq_window.sv
module trseq_window
    import trseq_pkg::*;
#(
    parameter  int NUM_ELEM = 8,
    parameter  int START_W  = 24,
    parameter  int LEN_W    = 16,
    parameter  int IDX_W    = 4,
    localparam int SEL_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic [NUM_ELEM*START_W-1:0] tbl_start,
    input  logic [NUM_ELEM*LEN_W-1:0]   tbl_len,
    input  logic [NUM_ELEM*KIND_W-1:0]  tbl_kind,
    input  logic [START_W-1:0]          cnt,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        active,
    output win_t                        win
);
    logic [START_W-1:0] starts [NUM_ELEM];
    logic [LEN_W-1:0]   lens   [NUM_ELEM];
    el_kind_t           kinds  [NUM_ELEM];

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_unpack
        assign starts[i] = tbl_start[i*START_W +: START_W];
        assign lens[i]   = tbl_len[i*LEN_W +: LEN_W];
        assign kinds[i]  = el_kind_t'(tbl_kind[i*KIND_W +: KIND_W]);
    end

    logic [SEL_W-1:0]   sel;
    logic [START_W-1:0] s_cur, off, l_ext;

    assign sel   = SEL_W'(idx);
    assign s_cur = starts[sel];
    assign l_ext = START_W'(lens[sel]);
    assign off   = cnt - s_cur;

    always_comb begin
        win.kind = kinds[sel];
        win.zero = active && (lens[sel] == '0);
        win.hit  = active && !win.zero && (cnt >= s_cur) && (off < l_ext);
        win.last = win.hit && (off == l_ext - 1'b1);
    end
endmodule

// File: rtl/tr_sequencer.sv
module tr_sequencer
    import trseq_pkg::*;
#(
    parameter  int NUM_ELEM   = 8,
    parameter  int START_W    = 24,
    parameter  int LEN_W      = 16,
    parameter  int CREDIT_MAX = 2,
    localparam int IDX_W      = $clog2(NUM_ELEM + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sync_in,
    input  logic                        smp_en,
    input  logic                        tr_loaded,
    input  logic                        pause,
    input  logic                        halt,
    input  logic [NUM_ELEM*START_W-1:0] tbl_start,
    input  logic [NUM_ELEM*LEN_W-1:0]   tbl_len,
    input  logic [NUM_ELEM*KIND_W-1:0]  tbl_kind,
    input  logic [IDX_W-1:0]            tbl_count,
    output logic                        dma_req,
    output logic [IDX_W-1:0]            elem_idx,
    output logic [GATE_W-1:0]           gate,
    output logic                        busy,
    output logic                        stopped,
    output logic                        overrun
);
    seq_state_t         state;
    logic [START_W-1:0] cnt;
    logic [IDX_W-1:0]   idx;
    logic               ovr;
    logic               sync_rise, have_credit, take_credit;
    logic               running, tick, adv;
    win_t               win;

    trseq_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .d    (sync_in),
        .rise (sync_rise)
    );

    assign take_credit = sync_rise && (state == ST_IDLE) && have_credit && !halt;

    trseq_credit #(.MAX(CREDIT_MAX)) u_credit (
        .clk   (clk),
        .rst   (rst),
        .give  (tr_loaded && (state != ST_STOP)),
        .take  (take_credit),
        .avail (have_credit)
    );

    assign running = (state == ST_RUN);

    trseq_window #(
        .NUM_ELEM (NUM_ELEM),
        .START_W  (START_W),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) u_win (
        .tbl_start (tbl_start),
        .tbl_len   (tbl_len),
        .tbl_kind  (tbl_kind),
        .cnt       (cnt),
        .idx       (idx),
        .active    (running && (idx < tbl_count)),
        .win       (win)
    );

    assign tick = running && smp_en && !pause;
    assign adv  = !pause && (win.zero || (tick && win.last));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            ovr   <= 1'b0;
        end else if (halt) begin
            state <= ST_STOP;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sync_rise) begin
                        if (have_credit) begin
                            state <= ST_RUN;
                            cnt   <= '0;
                            idx   <= '0;
                        end else begin
                            state <= ST_STOP;
                        end
                    end
                end
                ST_RUN: begin
                    if (sync_rise) ovr <= 1'b1;
                    if (tick) cnt <= cnt + 1'b1;
                    if (adv) begin
                        idx <= idx + 1'b1;
                        if (IDX_W'(idx + 1'b1) >= tbl_count) state <= ST_IDLE;
                    end else if (idx >= tbl_count) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

    assign dma_req  = tick && win.hit;
    assign gate     = win.hit ? kind_gate(win.kind) : '0;
    assign elem_idx = idx;
    assign busy     = running;
    assign stopped  = (state == ST_STOP);
    assign overrun  = ovr;
endmodule

// File: rtl/trseq_checker.sv
module trseq_checker #(
    parameter int IDX_W  = 4,
    parameter int GATE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_en,
    input logic              pause,
    input logic              halt,
    input logic              dma_req,
    input logic [IDX_W-1:0]  elem_idx,
    input logic [GATE_W-1:0] gate,
    input logic              busy,
    input logic              stopped,
    input logic              overrun
);
    AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (smp_en && !pause && busy)); // R3

    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate)); // R5

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        stopped |=> stopped); // R9

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        stopped |-> (!dma_req && gate == '0 && !busy)); // R9

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && pause && !halt) |=> $stable(elem_idx)); // R10

    AST_HALT_STOP: assert property (@(posedge clk) disable iff (rst)
        halt |=> (stopped && !busy)); // R11
endmodule

bind tr_sequencer trseq_checker #(.IDX_W(IDX_W), .GATE_W(trseq_pkg::GATE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .pause    (pause),
    .halt     (halt),
    .dma_req  (dma_req),
    .elem_idx (elem_idx),
    .gate     (gate),
    .busy     (busy),
    .stopped  (stopped),
    .overrun  (overrun)
);

// File: tb/sim_tr_sequencer.sv
module sim_tr_sequencer;
    localparam int N  = 8;
    localparam int SW = 24;
    localparam int LW = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0, smp_en = 1'b0, tr_loaded = 1'b0, pause = 1'b0, halt = 1'b0;
    logic [N*SW-1:0] tbl_start;
    logic [N*LW-1:0] tbl_len;
    logic [N*2-1:0]  tbl_kind;
    logic [IW-1:0]   tbl_count;
    logic            dma_req, busy, stopped, overrun;
    logic [IW-1:0]   elem_idx;
    logic [2:0]      gate;

    int st [N];
    int ln [N];
    int kd [N];
    int ne = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tbl_start[i*SW +: SW] = SW'(st[i]);
            tbl_len[i*LW +: LW]   = LW'(ln[i]);
            tbl_kind[i*2 +: 2]    = 2'(kd[i]);
        end
        tbl_count = IW'(ne);
    end

    tr_sequencer u0 (
        .clk(clk), .rst(rst), .sync_in(sync_in), .smp_en(smp_en),
        .tr_loaded(tr_loaded), .pause(pause), .halt(halt),
        .tbl_start(tbl_start), .tbl_len(tbl_len), .tbl_kind(tbl_kind),
        .tbl_count(tbl_count), .dma_req(dma_req), .elem_idx(elem_idx),
        .gate(gate), .busy(busy), .stopped(stopped), .overrun(overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int win_of(input int k);
        for (int e = 0; e < ne; e++)
            if (ln[e] != 0 && k >= st[e] && k < st[e] + ln[e]) return e;
        return -1;
    endfunction

    function automatic int gate_of(input int kind);
        case (kind)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int last_end();
        int m = 0;
        for (int e = 0; e < ne; e++)
            if (ln[e] != 0 && st[e] + ln[e] > m) m = st[e] + ln[e];
        return m;
    endfunction

    task automatic clear_tab();
        for (int i = 0; i < N; i++) begin st[i] = 0; ln[i] = 0; kd[i] = 0; end
        ne = 0;
    endtask

    task automatic put(input int e, input int s, input int l, input int k);
        st[e] = s; ln[e] = l; kd[e] = k;
        if (e + 1 > ne) ne = e + 1;
    endtask

    task automatic table_a();
        clear_tab();
        put(0, 2, 3, 0);
        put(1, 6, 2, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sync_in = 0; smp_en = 0; tr_loaded = 0; pause = 0; halt = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            tr_loaded = 1'b1;
            @(negedge clk);
            tr_loaded = 1'b0;
        end
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    // Runs one period after pulse_sync; gap = idle cycles between ticks
    task automatic run_tr(input int gap, input int pause_at, input int pause_len,
                          input int sync_at, input string tag);
        int k = 0;
        int c = 0;
        int endk = last_end();
        check(busy == 1'b1, {tag, " R2 start busy"}, busy, 1);
        check(elem_idx == 0, {tag, " R2 start idx"}, elem_idx, 0);
        while (k < endk && c < 2000) begin
            bit en, pa;
            int e, eg;
            en = (c % (gap + 1)) == 0;
            pa = (c >= pause_at) && (c < pause_at + pause_len);
            smp_en = en; pause = pa; sync_in = (c == sync_at);
            #1;
            e = win_of(k);
            eg = (e >= 0) ? gate_of(kd[e]) : 0;
            check(dma_req == (en && !pa && e >= 0), {tag, " R3 dma_req"}, dma_req,
                  int'(en && !pa && e >= 0));
            check(gate == 3'(eg), {tag, " R5 gate"}, gate, eg);
            if (e >= 0) check(elem_idx == IW'(e), {tag, " R4 elem_idx"}, elem_idx, e);
            if (pa && c > pause_at) check(elem_idx == IW'(e < 0 ? elem_idx : e),
                                           {tag, " R10 paused idx"}, elem_idx, e);
            if (en && !pa) k++;
            c++;
            @(negedge clk);
        end
        smp_en = 0; pause = 0; sync_in = 0;
        #1;
        check(busy == 1'b0, {tag, " R6 idle after last"}, busy, 0);
        check(gate == 3'b000, {tag, " R6 gates low"}, gate, 0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check(busy == 0 && stopped == 0 && overrun == 0, "R1 status", {busy, stopped, overrun}, 0);
        check(dma_req == 0 && gate == 0 && elem_idx == 0, "R1 outputs", {dma_req, gate, elem_idx}, 0);
    endtask

    task automatic t_basic();
        do_reset();
        table_a();
        load(1);
        pulse_sync();
        run_tr(0, 999, 0, -1, "basic");
        check(overrun == 0, "basic R7 no overrun", overrun, 0);
    endtask

    task automatic t_sparse_kinds();
        do_reset();
        clear_tab();
        put(0, 0, 2, 2);
        put(1, 4, 1, 3);
        put(2, 5, 2, 0);
        load(2);
        pulse_sync();
        run_tr(1, 999, 0, -1, "sparse");
        pulse_sync();
        run_tr(2, 999, 0, -1, "restart R6");
    endtask

    task automatic t_overrun();
        do_reset();
        table_a();
        load(1);
        pulse_sync();
        run_tr(0, 999, 0, 4, "overrun R7");
        check(overrun == 1, "R7 overrun set", overrun, 1);
        repeat (3) @(negedge clk);
        check(overrun == 1, "R7 overrun sticky", overrun, 1);
    endtask

    task automatic t_pause();
        do_reset();
        table_a();
        load(1);
        pulse_sync();
        run_tr(0, 3, 4, -1, "pause R10");
    endtask

    task automatic t_zero();
        do_reset();
        clear_tab();
        put(0, 1, 0, 0);
        put(1, 3, 1, 1);
        load(1);
        pulse_sync();
        run_tr(0, 999, 0, -1, "zero-len R4");
    endtask

    task automatic t_credit();
        do_reset();
        table_a();
        load(3);
        pulse_sync();
        run_tr(0, 999, 0, -1, "credit1 R8");
        pulse_sync();
        run_tr(0, 999, 0, -1, "credit2 R8");
        pulse_sync();
        #1;
        check(stopped == 1, "R8 out of credit stops", stopped, 1);
        check(busy == 0, "R8 out of credit not busy", busy, 0);
        // R9: stopped ignores loads and syncs
        load(1);
        pulse_sync();
        for (int i = 0; i < 8; i++) begin
            smp_en = 1'b1;
            #1;
            check(stopped == 1 && busy == 0, "R9 stays stopped", {stopped, busy}, 2);
            check(dma_req == 0 && gate == 0, "R9 quiet", {dma_req, gate}, 0);
            @(negedge clk);
        end
        smp_en = 1'b0;
    endtask

    task automatic t_halt();
        do_reset();
        table_a();
        load(2);
        pulse_sync();
        smp_en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(gate == 3'b001, "R11 in window before halt", gate, 1);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        #1;
        check(stopped == 1 && busy == 0, "R11 halted", {stopped, busy}, 2);
        check(dma_req == 0 && gate == 0, "R11 outputs dropped", {dma_req, gate}, 0);
        smp_en = 1'b0;
        pulse_sync();
        #1;
        check(busy == 0 && stopped == 1, "R9 sync ignored after halt", {busy, stopped}, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_sparse_kinds();
        t_overrun();
        t_pause();
        t_zero();
        t_credit();
        t_halt();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule